// File: doc/BRIEF.md
# Receive Character Synchronization Unit

This block finds character boundaries for one serial receive channel. Each rising edge of the receive clock brings in one data bit, least significant bit of a character first. A mode input selects how the boundary is found. In the two input modes an active-low sync pin is only read. In asynchronous mode that pin simply feeds a status bit. In external mode an outside device pulls it low to mark where a character begins. In the three internal modes the block compares the received bits with a pattern and drives the pin as an active-low pulse. The pattern is a programmable 8-bit character, a programmable 16-bit pair, or the fixed frame flag.

A hunt status bit is set while the receiver searches for a boundary. It clears on the first boundary found, and a hunt request sets it again. A one-cycle character-start strobe tells the downstream character assembler where to begin. The pin pulse in the internal modes is not latched. It fires on every match, whether or not the match falls on a character boundary.

Top module: `sync_hunt_unit`

## Requirements
- R1: After reset, hunt_status is 1, char_start is 0 and sync_out_n is 1. Received-bit history is empty, so no match is possible until enough bits have arrived since reset.
- R2: With mode 0 (asynchronous; codes 5 to 7 act the same), hunt_status equals the inverse of sync_in_n as sampled at the most recent receive-clock rising edge. char_start stays 0.
- R3: With mode 1 (external), while hunting: if sync_in_n is sampled low at one rising edge after being sampled high at the previous edge, char_start is 1 during the following cycle. The bit assembly then counts from the edge before that. hunt_status clears at the next edge.
- R4: With mode 2 (monosync), sync_out_n is 0 for exactly the cycle after each rising edge at which the last 8 bits received equal sync_pattern[7:0], with the earliest of them in bit 0. At least 8 bits must have arrived since reset. This happens on every match, overlapping or not.
- R5: With mode 3 (bisync), the same holds for the last 16 bits against sync_pattern[15:0], with the earliest bit in bit 0, so the low byte is received first. At least 16 bits must have arrived since reset.
- R6: With mode 4 (frame flag), the same holds for the last 8 bits against the flag 0x7E.
- R7: sync_oe is 1 exactly in modes 2, 3 and 4. Whenever sync_oe is 0, sync_out_n is 1.
- R8: In modes 2 to 4, char_start is 1 in a cycle where a match is shown while hunt_status is 1. hunt_status then clears at the next edge unless a hunt request is sampled there.
- R9: In modes 1 to 4, hunt_req sampled high at a rising edge sets hunt_status, and this wins over a clearing event at the same edge. In mode 0, hunt_req has no effect on hunt_status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk | input | 1 | Receive clock; one data bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_data | input | 1 | Receive data bit |
| mode | input | 3 | 0 async, 1 external, 2 monosync, 3 bisync, 4 frame flag |
| sync_pattern | input | 16 | Sync pattern; bits 7:0 for monosync, all for bisync |
| hunt_req | input | 1 | Request to re-enter hunt |
| sync_in_n | input | 1 | Sync pin level as read from the pad, active low |
| sync_out_n | output | 1 | Sync pin drive value, active low |
| sync_oe | output | 1 | Sync pin output enable |
| hunt_status | output | 1 | Hunt status bit |
| char_start | output | 1 | Character-assembly start strobe |

## Verification
The assertions assume that mode and sync_pattern change only while reset is held. A change in flight would let a match be judged against history gathered under another mode. The bench therefore sets each mode and pattern, then pulses reset before streaming bits. Within a run it mixes random bytes with embedded patterns and flags, dense overlapping patterns, random pin toggles and sparse hunt requests. This keeps the first-match, re-hunt and unaligned-match cases all in play.

// File: rtl/sync_hunt_unit.sv
module sync_hunt_unit #(
  parameter int CHAR_W = 8,
  parameter logic [CHAR_W-1:0] FLAG_CODE = 8'h7E
) (
  input  logic                rx_clk,
  input  logic                rst_n,
  input  logic                rx_data,
  input  logic [2:0]          mode,
  input  logic [2*CHAR_W-1:0] sync_pattern,
  input  logic                hunt_req,
  input  logic                sync_in_n,
  output logic                sync_out_n,
  output logic                sync_oe,
  output logic                hunt_status,
  output logic                char_start
);
  localparam int PAT_W = 2 * CHAR_W;
  localparam int CNT_W = $clog2(PAT_W + 1);
  localparam logic [2:0] M_EXT  = 3'd1;
  localparam logic [2:0] M_MONO = 3'd2;
  localparam logic [2:0] M_BI   = 3'd3;
  localparam logic [2:0] M_FLAG = 3'd4;

  logic [PAT_W-1:0] shreg;
  logic [CNT_W-1:0] fill;
  logic             pin_s, pin_p, hunt_q;

  wire is_ext   = (mode == M_EXT);
  wire is_mono  = (mode == M_MONO);
  wire is_bi    = (mode == M_BI);
  wire is_flag  = (mode == M_FLAG);
  wire internal = is_mono | is_bi | is_flag;

  wire have_char = fill >= CNT_W'(CHAR_W);
  wire have_pair = fill == CNT_W'(PAT_W);
  wire [CHAR_W-1:0] last_char = shreg[PAT_W-1 -: CHAR_W];

  wire match = (is_mono & have_char & (last_char == sync_pattern[CHAR_W-1:0]))
             | (is_bi   & have_pair & (shreg == sync_pattern))
             | (is_flag & have_char & (last_char == FLAG_CODE));

  wire ext_event = is_ext & hunt_q & pin_s & ~pin_p;

  assign char_start  = ext_event | (internal & hunt_q & match);
  assign sync_oe     = internal;
  assign sync_out_n  = ~(internal & match);
  assign hunt_status = hunt_q;

  always_ff @(posedge rx_clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      fill   <= '0;
      pin_s  <= 1'b0;
      pin_p  <= 1'b0;
      hunt_q <= 1'b1;
    end else begin
      shreg <= {rx_data, shreg[PAT_W-1:1]};
      if (fill != CNT_W'(PAT_W)) fill <= fill + 1'b1;
      pin_s <= ~sync_in_n;
      pin_p <= pin_s;
      if (!(internal | is_ext)) hunt_q <= ~sync_in_n;
      else if (hunt_req)        hunt_q <= 1'b1;
      else if (char_start)      hunt_q <= 1'b0;
    end
  end
endmodule

module sync_hunt_unit_chk (
  input logic       rx_clk,
  input logic       rst_n,
  input logic [2:0] mode,
  input logic       hunt_req,
  input logic       sync_in_n,
  input logic       sync_out_n,
  input logic       sync_oe,
  input logic       hunt_status,
  input logic       char_start
);
  a_r7_idle_pin_high: assert property (@(posedge rx_clk) disable iff (!rst_n)
    !sync_oe |-> sync_out_n);
  a_r4_pulse_only_driven: assert property (@(posedge rx_clk) disable iff (!rst_n)
    !sync_out_n |-> sync_oe);
  a_r8_start_while_hunting: assert property (@(posedge rx_clk) disable iff (!rst_n)
    char_start |-> hunt_status);
  a_r8_hunt_clears: assert property (@(posedge rx_clk) disable iff (!rst_n)
    (char_start && !hunt_req) |=> !hunt_status);
  a_r9_hunt_req_sets: assert property (@(posedge rx_clk) disable iff (!rst_n)
    (hunt_req && mode inside {3'd1, 3'd2, 3'd3, 3'd4}) |=> hunt_status);
  a_r2_async_no_start: assert property (@(posedge rx_clk) disable iff (!rst_n)
    (mode == 3'd0) |-> !char_start);
  a_r2_async_status: assert property (@(posedge rx_clk) disable iff (!rst_n)
    (mode == 3'd0) |=> (hunt_status == !$past(sync_in_n)));
endmodule

bind sync_hunt_unit sync_hunt_unit_chk chk_i (
  .rx_clk(rx_clk), .rst_n(rst_n), .mode(mode), .hunt_req(hunt_req),
  .sync_in_n(sync_in_n), .sync_out_n(sync_out_n), .sync_oe(sync_oe),
  .hunt_status(hunt_status), .char_start(char_start)
);

// File: tb/sync_hunt_unit_tb_top.sv
`timescale 1ns/1ps
module sync_hunt_unit_tb_top;
  logic        rx_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_data = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [15:0] sync_pattern = 16'h0;
  logic        hunt_req = 1'b0;
  logic        sync_in_n = 1'b1;
  logic        sync_out_n, sync_oe, hunt_status, char_start;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 rx_clk = ~rx_clk;

  sync_hunt_unit dut_i (
    .rx_clk(rx_clk), .rst_n(rst_n), .rx_data(rx_data), .mode(mode),
    .sync_pattern(sync_pattern), .hunt_req(hunt_req), .sync_in_n(sync_in_n),
    .sync_out_n(sync_out_n), .sync_oe(sync_oe), .hunt_status(hunt_status),
    .char_start(char_start)
  );

  int  hist[$];
  int  txq[$];
  bit  m_pin_q, m_pin_qq, m_hunt, last_hreq, first_chk;
  int  low_left;

  function automatic int lastn(int k);
    int v = 0;
    for (int i = 0; i < k; i++) v |= hist[hist.size() - k + i] << i;
    return v;
  endfunction

  function automatic bit m_match();
    int n = hist.size();
    if (mode == 3'd2) return n >= 8 && lastn(8) == int'(sync_pattern[7:0]);
    if (mode == 3'd3) return n >= 16 && lastn(16) == int'(sync_pattern);
    if (mode == 3'd4) return n >= 8 && lastn(8) == 'h7E;
    return 1'b0;
  endfunction

  function automatic bit m_internal();
    return mode inside {3'd2, 3'd3, 3'd4};
  endfunction

  function automatic bit m_start();
    if (mode == 3'd1) return m_hunt && m_pin_q && !m_pin_qq;
    return m_internal() && m_hunt && m_match();
  endfunction

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    string tp, th, ts;
    tp = (mode == 3'd2) ? "R4" : (mode == 3'd3) ? "R5" : (mode == 3'd4) ? "R6" : "R7";
    th = (mode == 3'd1) ? "R3" : m_internal() ? "R8" : "R2";
    ts = th;
    if (last_hreq) th = "R9";
    if (first_chk) begin tp = "R1"; th = "R1"; ts = "R1"; end
    chk(tp, "sync_out_n", sync_out_n, !(m_internal() && m_match()));
    chk("R7", "sync_oe", sync_oe, m_internal());
    chk(th, "hunt_status", hunt_status, m_hunt);
    chk(ts, "char_start", char_start, m_start());
    first_chk = 1'b0;
  endtask

  task automatic push_bits(int v, int w);
    for (int i = 0; i < w; i++) txq.push_back((v >> i) & 1);
  endtask

  task automatic model_step();
    bit nh;
    bit ext = (mode == 3'd1);
    if (!m_internal() && !ext) nh = !sync_in_n;
    else if (hunt_req) nh = 1'b1;
    else if (m_start()) nh = 1'b0;
    else nh = m_hunt;
    hist.push_back(int'(rx_data));
    if (hist.size() > 16) void'(hist.pop_front());
    m_pin_qq = m_pin_q;
    m_pin_q = !sync_in_n;
    m_hunt = nh;
    last_hreq = hunt_req;
  endtask

  task automatic run_phase(logic [2:0] md, logic [15:0] pat, bit dense, int cycles);
    @(negedge rx_clk);
    rst_n = 1'b0;
    mode = md;
    sync_pattern = pat;
    hunt_req = 1'b0;
    sync_in_n = 1'b1;
    rx_data = 1'b0;
    txq.delete();
    hist.delete();
    m_pin_q = 0; m_pin_qq = 0; m_hunt = 1; last_hreq = 0; low_left = 0;
    repeat (3) @(negedge rx_clk);
    rst_n = 1'b1;
    first_chk = 1'b1;
    for (int c = 0; c < cycles; c++) begin
      compare();
      if (txq.size() == 0) begin
        int r = $urandom % 4;
        if (dense) push_bits(32'h5555, 16);
        else if (r == 0 && md == 3'd3) push_bits(int'(pat), 16);
        else if (r == 0 && md == 3'd4) push_bits('h7E, 8);
        else if (r == 0) push_bits(int'(pat[7:0]), 8);
        else push_bits(int'($urandom % 256), 8);
      end
      rx_data = txq.pop_front() != 0;
      hunt_req = ($urandom % 37) == 0;
      if (md == 3'd1) begin
        if (low_left > 0) low_left--;
        else if ($urandom % 11 == 0) low_left = 1 + $urandom % 4;
        sync_in_n = !(low_left > 0);
      end else if ($urandom % 5 == 0) begin
        sync_in_n = !sync_in_n;
      end
      model_step();
      @(negedge rx_clk);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    run_phase(3'd0, 16'h0000, 1'b0, 500);
    run_phase(3'd1, 16'h0000, 1'b0, 600);
    run_phase(3'd2, 16'h0096, 1'b0, 700);
    run_phase(3'd2, 16'h00AA, 1'b1, 300);
    run_phase(3'd3, 16'hA516, 1'b0, 800);
    run_phase(3'd4, 16'h0000, 1'b0, 700);
    run_phase(3'd2, 16'h0000, 1'b0, 400);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule